// File: doc/BRIEF.md
# Multi-cycle writeback slot allocator

This block places finished instructions into a commit-bound staging buffer. The buffer is a window of `LOOKAHEAD` future cycles, each with `SLOTS_PER_CYC` slots. Every clock the allocator takes up to `PORTS` requests, each carrying an instruction tag. It places each one in the earliest free slot, scanning slot by slot and cycle by cycle from the front of the window. When the front cycle is full, the request spills into a later cycle instead of stalling the producer.

On every clock where `hold` is low, the window moves one cycle toward the head. The cycle that leaves the window is shown on the head read port for one cycle, together with its occupancy count. While `hold` is high, the window stays in place and nothing is delivered. If a request finds no free slot anywhere in the window, it is dropped and a sticky overflow flag is raised.

Top module: `wbslot_alloc`

## Requirements
- R1: After reset, `head_valid` and `head_count` are zero, `overflow` is low, and no grant is given while no request is raised.
- R2: A request to an empty window is granted in the same cycle at cycle 0, slot 0. Cycle 0 means the next cycle to leave the window. After the next clock edge with `hold` low, the tag appears at `head_tag[0]` with `head_valid[0]` set.
- R3: Requests raised in the same cycle are served in ascending port order. The search resumes just past the previous grant. The slot index returns to 0 and the cycle index goes up by one once the slot index reaches `SLOTS_PER_CYC`.
- R4: Occupied slots are skipped. The grant reports the first free slot in linear order, where the linear position is cycle × `SLOTS_PER_CYC` + slot. `gnt_cyc` and `gnt_slot` carry that cycle and slot.
- R5: `head_count` always equals the number of set bits in `head_valid`. Each grant raises the stored count of its cycle by one.
- R6: On each clock edge with `hold` low, the window moves by exactly one cycle. An entry granted at cycle k reaches the head port k + 1 non-held edges later, in its granted slot.
- R7: On a clock edge with `hold` high, the window does not move. Grants are still stored, and after that edge `head_valid` and `head_count` are zero.
- R8: A request that finds no free slot in all `LOOKAHEAD` cycles is not granted, is not stored, and sets `overflow`.
- R9: `overflow` stays high until reset.
- R10: `gnt[i]` is high only when `req[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | PORTS | Per-port allocation request |
| req_tag | input | PORTS×TAG_W | Per-port instruction tag |
| hold | input | 1 | Freeze the window (no shift, no delivery) |
| gnt | output | PORTS | Per-port grant, same cycle as the request |
| gnt_cyc | output | PORTS×idx_bits(LOOKAHEAD) | Granted cycle offset |
| gnt_slot | output | PORTS×idx_bits(SLOTS_PER_CYC) | Granted slot within that cycle |
| overflow | output | 1 | Sticky flag: a request found no free slot |
| head_valid | output | SLOTS_PER_CYC | Valid bits of the delivered head cycle |
| head_tag | output | SLOTS_PER_CYC×TAG_W | Tags of the delivered head cycle |
| head_count | output | cnt_bits(SLOTS_PER_CYC) | Occupancy count of the delivered head cycle |

## Verification
The assertions check the following on every cycle:
- grants from different ports land on distinct slots, in strictly ascending linear order;
- every grant falls inside the window;
- each stored per-cycle count matches the valid bits of its cycle;
- the head count matches the head valid bits;
- a held edge delivers nothing;
- overflow stays set once raised, and rises only after an ungranted request.

Only the bench scenarios can show which exact slot each tag receives, and that the tag emerges from the head after the right number of shifts. The same applies to spill across cycle boundaries, delay under hold, and tags being dropped rather than stored once the window is full. The bench tracks these with an arithmetic model, sweeping request and hold patterns through the window.

// File: rtl/wbslot_pkg.sv
package wbslot_pkg;

    localparam int unsigned WB_DEF_SLOTS = 4;
    localparam int unsigned WB_DEF_AHEAD = 5;
    localparam int unsigned WB_DEF_TAG_W = 8;
    localparam int unsigned WB_DEF_PORTS = 2;

    // what the window does on a clock edge
    typedef enum logic {
        BUF_HOLD  = 1'b0,
        BUF_SHIFT = 1'b1
    } buf_act_e;

    // bits to index n things, never below one
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // bits to hold a count from 0 to n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wbslot_scan.sv
module wbslot_scan
    import wbslot_pkg::*;
#(
    parameter int unsigned W  = WB_DEF_SLOTS,
    parameter int unsigned D  = WB_DEF_AHEAD,
    parameter int unsigned TW = WB_DEF_TAG_W,
    parameter int unsigned P  = WB_DEF_PORTS
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [D*W-1:0]                          occ,
    input  logic [P-1:0]                            req,
    input  logic [P-1:0][TW-1:0]                    req_tag,
    output logic [P-1:0]                            gnt,
    output logic [P-1:0][wbslot_pkg::idx_bits(D)-1:0] gnt_cyc,
    output logic [P-1:0][wbslot_pkg::idx_bits(W)-1:0] gnt_slot,
    output logic [P-1:0]                            miss,
    output logic [D*W-1:0]                          wr_en,
    output logic [D*W-1:0][TW-1:0]                  wr_tag
);
    localparam int unsigned SLOTS  = D * W;
    localparam int unsigned CYC_W  = idx_bits(D);
    localparam int unsigned SLOT_W = idx_bits(W);

    logic [SLOTS-1:0] taken;
    logic             found;
    int unsigned      hit;
    int unsigned      pos;

    // Linear search; the start position begins at zero every clock and
    // resumes just past the previous port's grant.
    always_comb begin
        taken    = occ;
        wr_en    = '0;
        wr_tag   = '0;
        gnt      = '0;
        gnt_cyc  = '0;
        gnt_slot = '0;
        miss     = '0;
        pos      = 0;
        found    = 1'b0;
        hit      = 0;
        for (int i = 0; i < int'(P); i++) begin
            if (req[i]) begin
                found = 1'b0;
                hit   = 0;
                for (int unsigned p = 0; p < SLOTS; p++) begin
                    if (!found && p >= pos && !taken[p]) begin
                        found = 1'b1;
                        hit   = p;
                    end
                end
                if (found) begin
                    taken[hit]  = 1'b1;
                    wr_en[hit]  = 1'b1;
                    wr_tag[hit] = req_tag[i];
                    gnt[i]      = 1'b1;
                    gnt_cyc[i]  = CYC_W'(hit / W);
                    gnt_slot[i] = SLOT_W'(hit % W);
                    pos         = hit + 1;
                end else begin
                    miss[i] = 1'b1;
                end
            end
        end
    end

    genvar gi, gj;
    generate
        for (gi = 0; gi < P; gi++) begin : g_bound
            // R4
            grant_in_window_chk: assert property (@(posedge clk) disable iff (rst)
                gnt[gi] |-> (int'(gnt_cyc[gi]) < int'(D) && int'(gnt_slot[gi]) < int'(W)));
            // R10
            grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
                gnt[gi] |-> req[gi]);
            for (gj = gi + 1; gj < P; gj++) begin : g_pair
                // R3
                port_order_chk: assert property (@(posedge clk) disable iff (rst)
                    (gnt[gi] && gnt[gj]) |->
                    (int'(gnt_cyc[gi]) * int'(W) + int'(gnt_slot[gi]) <
                     int'(gnt_cyc[gj]) * int'(W) + int'(gnt_slot[gj])));
            end
        end
    endgenerate

endmodule

// File: rtl/wbslot_store.sv
module wbslot_store
    import wbslot_pkg::*;
#(
    parameter int unsigned W  = WB_DEF_SLOTS,
    parameter int unsigned D  = WB_DEF_AHEAD,
    parameter int unsigned TW = WB_DEF_TAG_W
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  buf_act_e                                act,
    input  logic [D*W-1:0]                          wr_en,
    input  logic [D*W-1:0][TW-1:0]                  wr_tag,
    output logic [D*W-1:0]                          occ,
    output logic [W-1:0]                            head_valid,
    output logic [W-1:0][TW-1:0]                    head_tag,
    output logic [wbslot_pkg::cnt_bits(W)-1:0]      head_count
);
    localparam int unsigned SLOTS = D * W;
    localparam int unsigned CNT_W = cnt_bits(W);

    logic [SLOTS-1:0]           vld_q, mrg_v, sh_v;
    logic [SLOTS-1:0][TW-1:0]   tag_q, mrg_t, sh_t;
    logic [D-1:0][CNT_W-1:0]    cnt_q, mrg_c, sh_c;

    assign occ = vld_q;

    // merge this clock's writes into the stored window
    always_comb begin
        mrg_v = vld_q | wr_en;
        for (int p = 0; p < int'(SLOTS); p++) begin
            mrg_t[p] = wr_en[p] ? wr_tag[p] : tag_q[p];
        end
    end

    genvar c;
    generate
        for (c = 0; c < D; c++) begin : g_cyc
            assign mrg_c[c] = cnt_q[c] + CNT_W'($countones(wr_en[c*W +: W]));
            if (c < D - 1) begin : g_mid
                assign sh_v[c*W +: W] = mrg_v[(c+1)*W +: W];
                assign sh_t[c*W +: W] = mrg_t[(c+1)*W +: W];
                assign sh_c[c]        = mrg_c[c+1];
            end else begin : g_top
                assign sh_v[c*W +: W] = '0;
                assign sh_t[c*W +: W] = '0;
                assign sh_c[c]        = '0;
            end
            // R5
            cycle_count_chk: assert property (@(posedge clk) disable iff (rst)
                cnt_q[c] == CNT_W'($countones(vld_q[c*W +: W])));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q      <= '0;
            tag_q      <= '0;
            cnt_q      <= '0;
            head_valid <= '0;
            head_tag   <= '0;
            head_count <= '0;
        end else if (act == BUF_SHIFT) begin
            vld_q      <= sh_v;
            tag_q      <= sh_t;
            cnt_q      <= sh_c;
            head_valid <= mrg_v[0 +: W];
            head_tag   <= mrg_t[0 +: W];
            head_count <= mrg_c[0];
        end else begin
            vld_q      <= mrg_v;
            tag_q      <= mrg_t;
            cnt_q      <= mrg_c;
            head_valid <= '0;
            head_tag   <= '0;
            head_count <= '0;
        end
    end

    // R5
    head_count_chk: assert property (@(posedge clk) disable iff (rst)
        head_count == CNT_W'($countones(head_valid)));

    // R7
    hold_no_delivery_chk: assert property (@(posedge clk) disable iff (rst)
        act == BUF_HOLD |=> (head_valid == '0 && head_count == '0));

    // R6
    head_cycle_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (act == BUF_SHIFT && vld_q[0 +: W] != '0) |=> head_valid != '0);

endmodule

// File: rtl/wbslot_alloc.sv
module wbslot_alloc
    import wbslot_pkg::*;
#(
    parameter int unsigned SLOTS_PER_CYC = WB_DEF_SLOTS,
    parameter int unsigned LOOKAHEAD     = WB_DEF_AHEAD,
    parameter int unsigned TAG_W         = WB_DEF_TAG_W,
    parameter int unsigned PORTS         = WB_DEF_PORTS
) (
    input  logic                                                clk,
    input  logic                                                rst,
    input  logic [PORTS-1:0]                                    req,
    input  logic [PORTS-1:0][TAG_W-1:0]                         req_tag,
    input  logic                                                hold,
    output logic [PORTS-1:0]                                    gnt,
    output logic [PORTS-1:0][wbslot_pkg::idx_bits(LOOKAHEAD)-1:0] gnt_cyc,
    output logic [PORTS-1:0][wbslot_pkg::idx_bits(SLOTS_PER_CYC)-1:0] gnt_slot,
    output logic                                                overflow,
    output logic [SLOTS_PER_CYC-1:0]                            head_valid,
    output logic [SLOTS_PER_CYC-1:0][TAG_W-1:0]                 head_tag,
    output logic [wbslot_pkg::cnt_bits(SLOTS_PER_CYC)-1:0]      head_count
);
    localparam int unsigned SLOTS = SLOTS_PER_CYC * LOOKAHEAD;

    logic [SLOTS-1:0]              occ;
    logic [SLOTS-1:0]              wr_en;
    logic [SLOTS-1:0][TAG_W-1:0]   wr_tag;
    logic [PORTS-1:0]              miss;
    logic                          ovf_q;
    buf_act_e                      act;

    assign act      = hold ? BUF_HOLD : BUF_SHIFT;
    assign overflow = ovf_q;

    wbslot_scan #(
        .W (SLOTS_PER_CYC), .D (LOOKAHEAD), .TW (TAG_W), .P (PORTS)
    ) u_scan (
        .clk      (clk),
        .rst      (rst),
        .occ      (occ),
        .req      (req),
        .req_tag  (req_tag),
        .gnt      (gnt),
        .gnt_cyc  (gnt_cyc),
        .gnt_slot (gnt_slot),
        .miss     (miss),
        .wr_en    (wr_en),
        .wr_tag   (wr_tag)
    );

    wbslot_store #(
        .W (SLOTS_PER_CYC), .D (LOOKAHEAD), .TW (TAG_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .wr_en      (wr_en),
        .wr_tag     (wr_tag),
        .occ        (occ),
        .head_valid (head_valid),
        .head_tag   (head_tag),
        .head_count (head_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (miss != '0) begin
            ovf_q <= 1'b1;
        end
    end

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R8
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(req & ~gnt) != '0);

endmodule

// File: tb/wbslot_alloc_tb.sv
`timescale 1ns/1ps
module wbslot_alloc_tb;
    localparam int W = 4;
    localparam int D = 5;
    localparam int P = 2;
    localparam int N = W * D;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [P-1:0]      req = '0;
    logic [P-1:0][7:0] req_tag = '0;
    logic              hold = 1'b0;
    logic [P-1:0]      gnt;
    logic [P-1:0][2:0] gnt_cyc;
    logic [P-1:0][1:0] gnt_slot;
    logic              overflow;
    logic [W-1:0]      head_valid;
    logic [W-1:0][7:0] head_tag;
    logic [2:0]        head_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model: occupied slots always form a prefix of length mn
    int       mn = 0;
    logic [7:0] mt [N];
    bit       movf = 0;
    logic [7:0] nt = 8'h10;

    always #2 clk = ~clk;

    wbslot_alloc u_dut (
        .clk(clk), .rst(rst), .req(req), .req_tag(req_tag), .hold(hold),
        .gnt(gnt), .gnt_cyc(gnt_cyc), .gnt_slot(gnt_slot), .overflow(overflow),
        .head_valid(head_valid), .head_tag(head_tag), .head_count(head_count)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = '0; hold = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        mn = 0; movf = 0;
        for (int i = 0; i < N; i++) mt[i] = '0;
        // R1
        chk(head_valid == '0, "R1 head_valid", int'(head_valid), 0);
        chk(head_count == '0, "R1 head_count", int'(head_count), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        chk(gnt == '0, "R1 gnt", int'(gnt), 0);
    endtask

    task automatic tick(input logic [P-1:0] r, input logic h);
        int ec;
        @(negedge clk);
        req = r; hold = h;
        for (int k = 0; k < P; k++) begin
            req_tag[k] = nt;
            nt = nt + 8'd1;
        end
        #1;
        for (int k = 0; k < P; k++) begin
            if (r[k]) begin
                if (mn < N) begin
                    // R3 R4: grant at linear position mn
                    chk(gnt[k] == 1'b1, "R2 gnt", int'(gnt[k]), 1);
                    chk(int'(gnt_cyc[k]) == mn / W, "R3 gnt_cyc", int'(gnt_cyc[k]), mn / W);
                    chk(int'(gnt_slot[k]) == mn % W, "R4 gnt_slot", int'(gnt_slot[k]), mn % W);
                    mt[mn] = req_tag[k];
                    mn++;
                end else begin
                    chk(gnt[k] == 1'b0, "R8 no grant when full", int'(gnt[k]), 0);
                    movf = 1;
                end
            end else begin
                chk(gnt[k] == 1'b0, "R10 gnt without req", int'(gnt[k]), 0);
            end
        end
        @(posedge clk); #1;
        if (!h) begin
            ec = (mn < W) ? mn : W;
            chk(int'(head_count) == ec, "R5 head_count", int'(head_count), ec);
            for (int s = 0; s < W; s++) begin
                if (s < ec) begin
                    chk(head_valid[s] == 1'b1, "R6 head_valid", int'(head_valid[s]), 1);
                    chk(head_tag[s] == mt[s], "R6 head_tag", int'(head_tag[s]), int'(mt[s]));
                end else begin
                    chk(head_valid[s] == 1'b0, "R6 head empty slot", int'(head_valid[s]), 0);
                end
            end
            for (int i = 0; i < N; i++) mt[i] = (i + W < N) ? mt[i + W] : 8'h00;
            mn = (mn > W) ? mn - W : 0;
        end else begin
            chk(head_valid == '0, "R7 hold head_valid", int'(head_valid), 0);
            chk(head_count == '0, "R7 hold head_count", int'(head_count), 0);
        end
        chk(overflow == movf, "R9 overflow", int'(overflow), int'(movf));
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 single request, empty window
        tick(2'b01, 1'b0);
        tick(2'b00, 1'b0);
        // R3 slot wrap into next cycle while held
        tick(2'b01, 1'b1);
        tick(2'b11, 1'b1);
        tick(2'b11, 1'b1);
        tick(2'b10, 1'b1);
        // R6 drain the held entries one cycle per edge
        for (int i = 0; i < 4; i++) tick(2'b00, 1'b0);
        // near-exhaustive sweep of request and hold patterns
        for (int i = 0; i < 320; i++) tick(2'(i % 4), (i % 11) >= 8);
        // R8 saturate the window under hold
        do_reset();
        for (int i = 0; i < 12; i++) tick(2'b11, 1'b1);
        // R9 overflow remains while the window drains
        for (int i = 0; i < 7; i++) tick(2'b00, 1'b0);
        tick(2'b01, 1'b0);
        // R1 reset clears the sticky flag
        do_reset();
        for (int i = 0; i < 20; i++) tick(2'b11, 1'b0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule